// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block turns a low-frequency oscillator, presented as a one-cycle enable `osc_tick` in the system clock domain, into a one-cycle pulse per second for a calendar. At the default parameters one second is 32,768 oscillator cycles. These are counted as 128 stages of 256 cycles each. Frequency error is corrected digitally rather than by trimming the crystal: within a repeating window of 64 minutes, the first second of some minutes is made shorter or longer. The number of such minutes is proportional to a signed 5-bit calibration code.

A positive code (sign bit 1) shortens the last stage of an affected second by half a stage, which is 128 cycles at the defaults, so the clock speeds up. A negative code (sign bit 0) adds one whole extra stage of 256 cycles, so the clock slows down. Magnitude N corrects minutes 0 through 2N-1 of the window, and no correction ever falls in the last two minutes. The block also marks the end of each minute. For production trimming it provides a square-wave test output at oscillator/64, which is 512 Hz. This output is gated by a test-enable flag and by a read of the seconds location.

While `stop` is high the whole chain is held cleared and produces no ticks. When `stop` is released, counting begins again at second 0 of minute 0 of the window.

Top module: `cal_prescaler`

## Requirements
- R1: During and just after reset, `sec_tick`, `min_strobe` and `ft_out` are 0.
- R2: With magnitude 0, the interval between consecutive `sec_tick` pulses is SEC_STAGES*2^STAGE_W oscillator ticks. The first interval after `stop` is released has the same length.
- R3: With `cal_sign`=1, the first second of each corrected minute lasts 2^(STAGE_W-1) ticks less than nominal.
- R4: With `cal_sign`=0, the first second of each corrected minute lasts 2^STAGE_W ticks more than nominal.
- R5: The corrected minutes are minute indices 0 to 2N-1 of a window of CYC_MIN minutes, where N = `cal_mag`, capped at CORR_MIN minutes. Every other second is nominal. The window repeats, so minute CYC_MIN is corrected like minute 0.
- R6: `min_strobe` is a one-cycle pulse. It is high exactly with the `sec_tick` that ends the last second (index SEC_PER_MIN-1) of a minute.
- R7: While `stop` is 1, no `sec_tick` occurs. After release, the window position restarts at minute 0, second 0.
- R8: Only cycles with `osc_tick`=1 advance the divider. With `osc_tick` high every other cycle, a nominal second spans twice as many system cycles.
- R9: When the test enable is set, `sec_rd`=1 and `stop`=0, `ft_out` is a square wave that stays high and low for 2^(FT_W-1) ticks each, whatever the calibration code. In any other case `ft_out` is 0.
- R10: A write (`ft_wr`=1) loads the test enable from `ft_wdata`. `pwr_down`=1 clears the enable and takes priority over a write in the same cycle.
- R11: `sec_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One oscillator cycle when high |
| stop | input | 1 | Holds divider and window position cleared |
| cal_sign | input | 1 | 1 = shorten (speed up), 0 = lengthen (slow down) |
| cal_mag | input | CAL_W | Correction magnitude N |
| ft_wr | input | 1 | Write strobe for the test-enable flag |
| ft_wdata | input | 1 | Value written to the test-enable flag |
| pwr_down | input | 1 | Power-down indication, clears the test enable |
| sec_rd | input | 1 | A read of the seconds location is in progress |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| min_strobe | output | 1 | One-cycle pulse at the end of each minute |
| ft_out | output | 1 | Frequency-test square wave |

## Verification
The bench measures the length of every second across a full window and into the next, under magnitudes 0, 1, 6 and 31 with both signs. A wrong bound on the corrected minutes would show up at minute 2N or minute 62. A window that fails to wrap would leave minute 64 uncorrected, and a shortening or stretching of the wrong size would give the wrong interval. It stops the block in the middle of the window and checks that the next second is the corrected minute-0 second, which a block that kept its position would not produce. It also runs the oscillator at half rate, checks the test-output run lengths under two calibration codes, and checks that power-down wins over a simultaneous write of the test enable.

// File: rtl/cal_prescaler_pkg.sv
package cal_prescaler_pkg;

    typedef enum logic [1:0] {
        CORR_NONE = 2'd0,
        CORR_FAST = 2'd1,
        CORR_SLOW = 2'd2
    } corr_e;

    // Decide the treatment of the current second from its window position.
    function automatic corr_e pick_corr(
        input logic        first_sec,
        input int unsigned min_idx,
        input int unsigned mag,
        input logic        sign,
        input int unsigned corr_min
    );
        int unsigned span;
        span = 2 * mag;
        if (span > corr_min) span = corr_min;
        if (first_sec && (min_idx < span))
            return sign ? CORR_FAST : CORR_SLOW;
        return CORR_NONE;
    endfunction

endpackage

// File: rtl/cal_stage_div.sv
module cal_stage_div #(
    parameter int STAGE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic osc_tick,
    input  logic half,
    output logic stage_done
);
    localparam logic [STAGE_W-1:0] FULL_LIM = {STAGE_W{1'b1}};
    localparam logic [STAGE_W-1:0] HALF_LIM = STAGE_W'((1 << (STAGE_W - 1)) - 1);

    logic [STAGE_W-1:0] pre_cnt;

    assign stage_done = osc_tick && (pre_cnt == (half ? HALF_LIM : FULL_LIM));

    always_ff @(posedge clk) begin
        if (rst || clr)
            pre_cnt <= '0;
        else if (osc_tick)
            pre_cnt <= stage_done ? '0 : pre_cnt + 1'b1;
    end
endmodule

// File: rtl/cal_second_seq.sv
module cal_second_seq
    import cal_prescaler_pkg::*;
#(
    parameter int SEC_STAGES = 128
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  stage_done,
    input  corr_e mode,
    output logic  half,
    output logic  sec_end
);
    localparam int ST_W = $clog2(SEC_STAGES + 1);
    localparam logic [ST_W-1:0] LAST_NORM = ST_W'(SEC_STAGES - 1);
    localparam logic [ST_W-1:0] LAST_SLOW = ST_W'(SEC_STAGES);

    logic [ST_W-1:0] st_cnt;
    logic [ST_W-1:0] last_st;

    assign last_st = (mode == CORR_SLOW) ? LAST_SLOW : LAST_NORM;
    assign half    = (mode == CORR_FAST) && (st_cnt == LAST_NORM);
    assign sec_end = stage_done && (st_cnt == last_st);

    always_ff @(posedge clk) begin
        if (rst || clr)
            st_cnt <= '0;
        else if (stage_done)
            st_cnt <= sec_end ? '0 : st_cnt + 1'b1;
    end
endmodule

// File: rtl/cal_window_pos.sv
module cal_window_pos #(
    parameter int SEC_PER_MIN = 60,
    parameter int CYC_MIN     = 64,
    localparam int SEC_W = $clog2(SEC_PER_MIN),
    localparam int MIN_W = $clog2(CYC_MIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             sec_end,
    output logic [SEC_W-1:0] sec_idx,
    output logic [MIN_W-1:0] min_idx,
    output logic             min_end
);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(CYC_MIN - 1);

    assign min_end = sec_end && (sec_idx == SEC_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sec_idx <= '0;
            min_idx <= '0;
        end else if (sec_end) begin
            sec_idx <= min_end ? '0 : sec_idx + 1'b1;
            if (min_end)
                min_idx <= (min_idx == MIN_LAST) ? '0 : min_idx + 1'b1;
        end
    end
endmodule

// File: rtl/cal_ftest_gen.sv
module cal_ftest_gen #(
    parameter int FT_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic stop,
    input  logic osc_tick,
    input  logic ft_wr,
    input  logic ft_wdata,
    input  logic pwr_down,
    input  logic sec_rd,
    output logic ft_out
);
    logic [FT_W-1:0] wave_cnt;
    logic            ft_en;

    always_ff @(posedge clk) begin
        if (rst)
            ft_en <= 1'b0;
        else if (pwr_down)
            ft_en <= 1'b0;
        else if (ft_wr)
            ft_en <= ft_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || stop)
            wave_cnt <= '0;
        else if (osc_tick)
            wave_cnt <= wave_cnt + 1'b1;
    end

    assign ft_out = ft_en && sec_rd && !stop && wave_cnt[FT_W-1];
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
    import cal_prescaler_pkg::*;
#(
    parameter int STAGE_W     = 8,
    parameter int SEC_STAGES  = 128,
    parameter int SEC_PER_MIN = 60,
    parameter int CYC_MIN     = 64,
    parameter int CORR_MIN    = 62,
    parameter int CAL_W       = 5,
    parameter int FT_W        = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             stop,
    input  logic             cal_sign,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             ft_wr,
    input  logic             ft_wdata,
    input  logic             pwr_down,
    input  logic             sec_rd,
    output logic             sec_tick,
    output logic             min_strobe,
    output logic             ft_out
);
    localparam int SEC_W = $clog2(SEC_PER_MIN);
    localparam int MIN_W = $clog2(CYC_MIN);

    logic             stage_done;
    logic             half;
    logic             sec_end;
    logic             min_end;
    logic [SEC_W-1:0] sec_idx;
    logic [MIN_W-1:0] min_idx;
    corr_e            mode;

    assign mode = pick_corr(sec_idx == '0, 32'(min_idx), 32'(cal_mag),
                            cal_sign, 32'(CORR_MIN));

    cal_stage_div #(.STAGE_W(STAGE_W)) u_div (
        .clk(clk), .rst(rst), .clr(stop), .osc_tick(osc_tick),
        .half(half), .stage_done(stage_done)
    );

    cal_second_seq #(.SEC_STAGES(SEC_STAGES)) u_seq (
        .clk(clk), .rst(rst), .clr(stop), .stage_done(stage_done),
        .mode(mode), .half(half), .sec_end(sec_end)
    );

    cal_window_pos #(.SEC_PER_MIN(SEC_PER_MIN), .CYC_MIN(CYC_MIN)) u_pos (
        .clk(clk), .rst(rst), .clr(stop), .sec_end(sec_end),
        .sec_idx(sec_idx), .min_idx(min_idx), .min_end(min_end)
    );

    cal_ftest_gen #(.FT_W(FT_W)) u_ft (
        .clk(clk), .rst(rst), .stop(stop), .osc_tick(osc_tick),
        .ft_wr(ft_wr), .ft_wdata(ft_wdata), .pwr_down(pwr_down),
        .sec_rd(sec_rd), .ft_out(ft_out)
    );

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            sec_tick   <= 1'b0;
            min_strobe <= 1'b0;
        end else begin
            sec_tick   <= sec_end;
            min_strobe <= min_end;
        end
    end
endmodule

// File: rtl/cal_prescaler_chk.sv
module cal_prescaler_chk (
    input logic clk,
    input logic rst,
    input logic osc_tick,
    input logic stop,
    input logic pwr_down,
    input logic sec_rd,
    input logic sec_tick,
    input logic min_strobe,
    input logic ft_out
);
    // R11
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

    // R6
    min_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
        min_strobe |-> sec_tick);

    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> !sec_tick);

    // R8
    tick_needs_osc_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_tick) |-> $past(osc_tick));

    // R10
    pwr_clears_ft_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> !ft_out);

    // R9
    ft_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        !sec_rd |-> !ft_out);
endmodule

bind cal_prescaler cal_prescaler_chk u_chk (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .stop(stop),
    .pwr_down(pwr_down), .sec_rd(sec_rd), .sec_tick(sec_tick),
    .min_strobe(min_strobe), .ft_out(ft_out)
);

// File: tb/cal_prescaler_test.sv
module cal_prescaler_test;
    localparam int STAGE_W = 3;
    localparam int SEC_STAGES = 4;
    localparam int SEC_PER_MIN = 4;
    localparam int CYC_MIN = 64;
    localparam int CORR_MIN = 62;
    localparam int CAL_W = 5;
    localparam int FT_W = 3;
    localparam int NOM = SEC_STAGES * (1 << STAGE_W);
    localparam int FAST = NOM - (1 << (STAGE_W - 1));
    localparam int SLOW = NOM + (1 << STAGE_W);
    localparam int HALF_WAVE = 1 << (FT_W - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b1;
    logic stop = 1'b1;
    logic cal_sign = 1'b0;
    logic [CAL_W-1:0] cal_mag = '0;
    logic ft_wr = 1'b0;
    logic ft_wdata = 1'b0;
    logic pwr_down = 1'b0;
    logic sec_rd = 1'b0;
    logic sec_tick, min_strobe, ft_out;
    logic half_rate = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    cal_prescaler #(
        .STAGE_W(STAGE_W), .SEC_STAGES(SEC_STAGES), .SEC_PER_MIN(SEC_PER_MIN),
        .CYC_MIN(CYC_MIN), .CORR_MIN(CORR_MIN), .CAL_W(CAL_W), .FT_W(FT_W)
    ) uut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .stop(stop),
        .cal_sign(cal_sign), .cal_mag(cal_mag), .ft_wr(ft_wr),
        .ft_wdata(ft_wdata), .pwr_down(pwr_down), .sec_rd(sec_rd),
        .sec_tick(sec_tick), .min_strobe(min_strobe), .ft_out(ft_out)
    );

    always @(negedge clk) osc_tick <= half_rate ? ~osc_tick : 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Count negedges up to and including the next sec_tick.
    task automatic wait_tick(output int n);
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (sec_tick || n > 1000) break;
        end
    endtask

    task automatic restart(input logic sg, input int mag);
        @(negedge clk);
        stop = 1'b1;
        cal_sign = sg;
        cal_mag = CAL_W'(mag);
        @(negedge clk);
        @(negedge clk);
        stop = 1'b0;
    endtask

    function automatic int exp_len(input logic sg, input int mag, input int m, input int s);
        int span;
        span = (2 * mag > CORR_MIN) ? CORR_MIN : 2 * mag;
        if (s == 0 && (m % CYC_MIN) < span) return sg ? FAST : SLOW;
        return NOM;
    endfunction

    // R2 R3 R4 R5 R6: whole window plus one minute
    task automatic test_window(input logic sg, input int mag);
        int n;
        restart(sg, mag);
        for (int m = 0; m <= CYC_MIN; m++) begin
            for (int s = 0; s < SEC_PER_MIN; s++) begin
                wait_tick(n);
                chk(n == exp_len(sg, mag, m, s),
                    sg ? "R3/R5 second length" : "R4/R5 second length",
                    n, exp_len(sg, mag, m, s));
                chk(min_strobe == (s == SEC_PER_MIN - 1), "R6 minute strobe",
                    int'(min_strobe), int'(s == SEC_PER_MIN - 1));
            end
        end
    endtask

    // R7: stop mid window, no ticks, restart at minute 0
    task automatic test_stop();
        int n;
        int seen;
        restart(1'b1, 1);
        for (int i = 0; i < 10; i++) wait_tick(n);
        @(negedge clk);
        stop = 1'b1;
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sec_tick) seen++;
        end
        chk(seen == 0, "R7 no tick while stopped", seen, 0);
        stop = 1'b0;
        wait_tick(n);
        chk(n == FAST, "R7 restart at minute 0", n, FAST);
        wait_tick(n);
        chk(n == NOM, "R7 second 1 nominal", n, NOM);
    endtask

    // R8: half-rate oscillator doubles the second
    task automatic test_half_rate();
        int n;
        restart(1'b0, 0);
        half_rate = 1'b1;
        wait_tick(n);
        wait_tick(n);
        chk(n == 2 * NOM, "R8 half rate second", n, 2 * NOM);
        wait_tick(n);
        chk(n == 2 * NOM, "R8 half rate second", n, 2 * NOM);
        @(negedge clk);
        half_rate = 1'b0;
    endtask

    // R9: run lengths of the test wave
    task automatic test_wave(input logic sg, input int mag);
        logic prev;
        int run;
        int runs;
        restart(sg, mag);
        sec_rd = 1'b1;
        @(negedge clk);
        prev = ft_out;
        run = -1;
        runs = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (ft_out != prev) begin
                if (run > 0) begin
                    chk(run == HALF_WAVE, "R9 wave run length", run, HALF_WAVE);
                    runs++;
                end
                run = 1;
            end else if (run > 0) begin
                run++;
            end
            prev = ft_out;
        end
        chk(runs >= 8, "R9 wave toggles", runs, 8);
    endtask

    task automatic test_ft_ctrl();
        int hi;
        @(negedge clk);
        ft_wr = 1'b1;
        ft_wdata = 1'b1;
        @(negedge clk);
        ft_wr = 1'b0;
        sec_rd = 1'b0;
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ft_out) hi++;
        end
        chk(hi == 0, "R9 no wave without read", hi, 0);
        sec_rd = 1'b1;
        // R10: power-down wins over a write of 1
        pwr_down = 1'b1;
        ft_wr = 1'b1;
        ft_wdata = 1'b1;
        @(negedge clk);
        pwr_down = 1'b0;
        ft_wr = 1'b0;
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ft_out) hi++;
        end
        chk(hi == 0, "R10 power-down clears enable", hi, 0);
        ft_wr = 1'b1;
        ft_wdata = 1'b1;
        @(negedge clk);
        ft_wdata = 1'b0;
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ft_out) hi++;
        end
        ft_wr = 1'b0;
        chk(hi == 0, "R10 write 0 clears enable", hi, 0);
        sec_rd = 1'b0;
    endtask

    initial begin
        int bad;
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (sec_tick || min_strobe || ft_out) bad++;
        end
        rst = 1'b0;
        @(negedge clk);
        if (sec_tick || min_strobe || ft_out) bad++;
        chk(bad == 0, "R1 reset outputs low", bad, 0);

        test_window(1'b0, 0);
        test_window(1'b1, 1);
        test_window(1'b0, 6);
        test_window(1'b1, 31);
        test_stop();
        test_half_rate();
        @(negedge clk);
        ft_wr = 1'b1;
        ft_wdata = 1'b1;
        @(negedge clk);
        ft_wr = 1'b0;
        test_wave(1'b0, 0);
        test_wave(1'b1, 31);
        test_ft_ctrl();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule